// File: doc/BRIEF.md
# PWM Duty to Reference Converter

This block turns the duty cycle of a synchronized pulse-width input into an 8-bit reference code. Code 255 stands for the full 200 mV feedback reference, and a lower duty scales the code in proportion. The code replaces a chopped reference followed by an analog low-pass filter, so the number it gives is a smoothed DC level and not a replica of the pulses. Every rise-to-rise period is timed in sampling-clock cycles. The high count is divided by the period count, so the result depends only on timing and never on the logic-high voltage of the source. The input frequency range is 10 kHz to 100 kHz. With a 50 MHz sampling clock, a period is 500 to 5000 cycles, and the shortest high pulses are 100 ns or 5 cycles.

Each per-period measurement passes through a first-order IIR stage, and the filtered value goes out on a valid/ready stream. An input that stops toggling is caught by a time-out longer than one 10 kHz period. A stuck-high input goes to full scale, and a stuck-low input keeps the last level. The mode controller drives `mode_en` high only while the part is in PWM mode. While it is low, the block is idle.

Back-pressure rules for the stream:
- Once `ref_valid` is raised, it stays high and `ref_data` stays stable until a cycle with `ref_ready` high.
- A result that completes while an earlier one is still waiting still updates the filter, but it is never offered on the port.
- The next result after the handshake carries the filter state, which includes every measurement taken so far.

Top module: `pwm_duty_ref`

## Requirements
- R1: After reset, `ref_valid` is 0 and `ref_data` is 255, which is full scale.
- R2: For a period of P cycles, counted from one sampled rise of `pwm_in` to the next, with H cycles sampled high, the measurement is floor(256*H/P). The first rise after reset, after a time-out, or after `mode_en` rises only starts a period and produces no result.
- R3: Each measurement m updates the filter state s to s + floor((m - s) / 2^FILT_SHIFT), using signed arithmetic. The new state is offered on the output stream. The state starts at 255.
- R4: If `pwm_in` is high when TIMEOUT_CYC cycles have passed without a rise, the state becomes 255 and 255 is offered once.
- R5: If `pwm_in` is low when that time-out expires, no result is produced and `ref_data` keeps its value.
- R6: Periods from 500 to 5000 cycles, and high times down to 5 cycles, are measured by the R2 formula with no loss of resolution.
- R7: While `mode_en` is 0, no new result is raised and the state is kept. When it rises again, measurement starts over as described in R2.
- R8: While `ref_valid` is high and `ref_ready` is low, `ref_valid` stays high and `ref_data` does not change. A result that completes in that time updates the state but is not offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwm_in | input | 1 | Synchronized dimming pin level |
| mode_en | input | 1 | High while PWM dimming mode is active |
| ref_valid | output | 1 | Stream valid for the reference code |
| ref_ready | input | 1 | Stream ready from the consumer |
| ref_data | output | 8 | Filtered reference code, 255 = 200 mV |

## Verification
The duty patterns cover both ends of the frequency range at 1 % duty, a middle duty, and duties close to 100 %. Together they separate rounding errors in the divider from errors in how the high and period counts are framed. Successive patterns with different duties show the IIR step and its floor rounding, which a stage that passes the raw measurement through would not show. A stuck-high input and a stuck-low input, each held past the time-out, separate snapping to full scale from holding the last value. A mode-off stretch and a stalled consumer show that pulses are ignored while the mode is off, that the first rise after re-entry only starts a period, and that results finishing during a stall still reach the filter.

// File: rtl/ref_conv_pkg.sv
package ref_conv_pkg;
  localparam int CODE_W = 8;
  typedef logic [CODE_W-1:0] code_t;
  localparam code_t CODE_FULL = '1;
endpackage

// File: rtl/duty_period_meter.sv
module duty_period_meter #(
  parameter int TIMEOUT_CYC = 6000,
  parameter int CNT_W = $clog2(TIMEOUT_CYC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             pin,
  output logic             samp_vld,
  output logic [CNT_W-1:0] samp_hi,
  output logic [CNT_W-1:0] samp_per,
  output logic             snap
);
  localparam logic [CNT_W-1:0] TMO = CNT_W'(TIMEOUT_CYC);

  logic             pin_d;
  logic             armed;
  logic [CNT_W-1:0] per_cnt;
  logic [CNT_W-1:0] hi_cnt;
  logic             rise;

  assign rise = pin & ~pin_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_d    <= 1'b0;
      armed    <= 1'b0;
      per_cnt  <= '0;
      hi_cnt   <= '0;
      samp_vld <= 1'b0;
      samp_hi  <= '0;
      samp_per <= '0;
      snap     <= 1'b0;
    end else begin
      pin_d    <= pin;
      samp_vld <= 1'b0;
      snap     <= 1'b0;
      if (!en) begin
        armed   <= 1'b0;
        per_cnt <= '0;
        hi_cnt  <= '0;
      end else if (rise) begin
        samp_vld <= armed;
        samp_hi  <= hi_cnt;
        samp_per <= per_cnt;
        armed    <= 1'b1;
        per_cnt  <= CNT_W'(1);
        hi_cnt   <= CNT_W'(1);
      end else if (per_cnt < TMO) begin
        per_cnt <= per_cnt + CNT_W'(1);
        hi_cnt  <= hi_cnt + CNT_W'(pin);
        if (per_cnt == TMO - CNT_W'(1)) begin
          armed <= 1'b0;
          snap  <= pin;
        end
      end
    end
  end

  AST_HI_BELOW_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    samp_vld |-> (samp_hi < samp_per)); // R2
  AST_NO_SAMPLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !samp_vld && !snap); // R7
endmodule

// File: rtl/duty_ratio_divider.sv
module duty_ratio_divider
  import ref_conv_pkg::*;
#(
  parameter int CNT_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] num,
  input  logic [CNT_W-1:0] den,
  output logic             done,
  output code_t            quo
);
  localparam int IT_W = $clog2(CODE_W + 1);
  localparam int PW   = CNT_W + CODE_W + 1;

  logic             busy;
  logic [IT_W-1:0]  bits_left;
  logic [CNT_W:0]   rem;
  logic [CNT_W-1:0] den_q;
  logic [CNT_W-1:0] num_q;
  logic [CNT_W:0]   rem2;
  logic             fits;

  always_comb begin
    rem2 = {rem[CNT_W-1:0], 1'b0};
    fits = rem2 >= {1'b0, den_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      bits_left <= '0;
      rem       <= '0;
      den_q     <= '0;
      num_q     <= '0;
      quo       <= '0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          rem       <= {1'b0, num};
          den_q     <= den;
          num_q     <= num;
          quo       <= '0;
          bits_left <= IT_W'(CODE_W);
          busy      <= 1'b1;
        end
      end else begin
        rem       <= fits ? (rem2 - {1'b0, den_q}) : rem2;
        quo       <= {quo[CODE_W-2:0], fits};
        bits_left <= bits_left - IT_W'(1);
        if (bits_left == IT_W'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  logic [PW-1:0] scaled, prod_lo, prod_hi;
  always_comb begin
    scaled  = PW'(num_q) << CODE_W;
    prod_lo = PW'(quo) * PW'(den_q);
    prod_hi = prod_lo + PW'(den_q);
  end

  AST_QUOT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (prod_lo <= scaled) && (scaled < prod_hi)); // R2
endmodule

// File: rtl/ref_smooth_iir.sv
module ref_smooth_iir
  import ref_conv_pkg::*;
#(
  parameter int FILT_SHIFT = 2
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  en,
  input  logic  meas_vld,
  input  code_t meas,
  input  logic  snap,
  output code_t state_q,
  output logic  upd
);
  code_t nxt;

  generate
    if (FILT_SHIFT == 0) begin : g_direct
      assign nxt = meas;
    end else begin : g_iir
      logic signed [CODE_W:0] diff, step;
      always_comb begin
        diff = $signed({1'b0, meas}) - $signed({1'b0, state_q});
        step = diff >>> FILT_SHIFT;
        nxt  = code_t'($unsigned($signed({1'b0, state_q}) + step));
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CODE_FULL;
      upd     <= 1'b0;
    end else begin
      upd <= 1'b0;
      if (en && snap) begin
        state_q <= CODE_FULL;
        upd     <= 1'b1;
      end else if (en && meas_vld) begin
        state_q <= nxt;
        upd     <= 1'b1;
      end
    end
  end

  AST_SNAP_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    en && snap |=> (state_q == CODE_FULL) && upd); // R4
  AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(en && (snap || meas_vld)) |=> $stable(state_q) && !upd); // R5
  AST_STEP_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
    en && meas_vld && !snap |=>
      (($past(meas) >= $past(state_q)) ?
        (state_q >= $past(state_q) && state_q <= $past(meas)) :
        (state_q <= $past(state_q) && state_q >= $past(meas)))); // R3
endmodule

// File: rtl/pwm_duty_ref.sv
module pwm_duty_ref
  import ref_conv_pkg::*;
#(
  parameter int TIMEOUT_CYC = 6000,
  parameter int FILT_SHIFT  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwm_in,
  input  logic              mode_en,
  output logic              ref_valid,
  input  logic              ref_ready,
  output logic [CODE_W-1:0] ref_data
);
  localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);

  logic             samp_vld, snap, div_done, filt_upd;
  logic [CNT_W-1:0] samp_hi, samp_per;
  code_t            div_q, filt_q;

  duty_period_meter #(.TIMEOUT_CYC(TIMEOUT_CYC), .CNT_W(CNT_W)) u_meter (
    .clk(clk), .rst_n(rst_n), .en(mode_en), .pin(pwm_in),
    .samp_vld(samp_vld), .samp_hi(samp_hi), .samp_per(samp_per), .snap(snap)
  );

  duty_ratio_divider #(.CNT_W(CNT_W)) u_div (
    .clk(clk), .rst_n(rst_n), .start(samp_vld), .num(samp_hi),
    .den(samp_per), .done(div_done), .quo(div_q)
  );

  ref_smooth_iir #(.FILT_SHIFT(FILT_SHIFT)) u_filt (
    .clk(clk), .rst_n(rst_n), .en(mode_en), .meas_vld(div_done),
    .meas(div_q), .snap(snap), .state_q(filt_q), .upd(filt_upd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_valid <= 1'b0;
      ref_data  <= CODE_FULL;
    end else if (filt_upd && (!ref_valid || ref_ready)) begin
      ref_valid <= 1'b1;
      ref_data  <= filt_q;
    end else if (ref_ready) begin
      ref_valid <= 1'b0;
    end
  end

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    ref_valid && !ref_ready |=> ref_valid && $stable(ref_data)); // R8
  AST_IDLE_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_en && !ref_valid |=> !ref_valid); // R7
endmodule

// File: tb/test_pwm_duty_ref.sv
module test_pwm_duty_ref;
  localparam int TO = 6000;
  localparam int FS = 1;
  localparam int NV = 6;
  localparam int VEC [NV][3] = '{
    '{50, 5000, 2}, '{5, 500, 3}, '{250, 500, 3},
    '{1500, 2000, 3}, '{4950, 5000, 2}, '{999, 1000, 2}};

  logic clk = 0, rst_n = 0, pwm_in = 0, mode_en = 0, ref_ready = 1;
  logic ref_valid;
  logic [7:0] ref_data;

  always #10 clk = ~clk;

  pwm_duty_ref #(.TIMEOUT_CYC(TO), .FILT_SHIFT(FS)) i_pwm_duty_ref (
    .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .mode_en(mode_en),
    .ref_valid(ref_valid), .ref_ready(ref_ready), .ref_data(ref_data));

  int n_chk = 0, n_fail = 0;
  int mstate = 255, have_prev = 0, prev_h = 0, prev_p = 1, port_busy = 0;
  int exp_v [0:255];
  string exp_t [0:255];
  int wr = 0, rd = 0;
  bit done = 0;

  task automatic chk(bit ok, string req, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic void model_apply(int m, string tag, bit snapv);
    int d;
    if (snapv) mstate = 255;
    else begin
      d = m - mstate;
      mstate = mstate + (d >>> FS);
    end
    if (!ref_ready && port_busy != 0) return; // R8: dropped from port
    if (!ref_ready) port_busy = 1;
    exp_v[wr] = mstate;
    exp_t[wr] = tag;
    wr++;
  endfunction

  task automatic drive(bit v, int n);
    repeat (n) begin
      @(negedge clk);
      #1 pwm_in = v;
    end
  endtask

  task automatic period(int h, int p, string tag);
    if (have_prev != 0) model_apply((prev_h * 256) / prev_p, tag, 0);
    prev_h = h; prev_p = p; have_prev = 1;
    drive(1, h);
    drive(0, p - h);
  endtask

  task automatic hold_high(int n);
    if (have_prev != 0) model_apply((prev_h * 256) / prev_p, "R2", 0);
    model_apply(255, "R4 stuck high", 1);
    have_prev = 0;
    drive(1, n);
    drive(0, 20);
  endtask

  // monitor: samples 5 ns after the falling edge, inputs change 1 ns after it
  bit pv = 0, pr = 1;
  logic [7:0] pd = 0;
  always begin
    @(negedge clk);
    #5;
    if (rst_n && !done) begin
      if (pv && !pr)
        chk(ref_valid && ref_data == pd, "R8 stall hold", ref_data, pd);
      if (ref_valid && ref_ready) begin
        if (rd >= wr) chk(0, "R5/R7 unexpected result", ref_data, -1);
        else begin
          chk(ref_data == exp_v[rd], exp_t[rd], ref_data, exp_v[rd]);
          rd++;
        end
      end
      pv = ref_valid; pr = ref_ready; pd = ref_data;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog all actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    #5;
    chk(ref_valid == 0, "R1 valid", ref_valid, 0);
    chk(ref_data == 255, "R1 data", ref_data, 255);
    @(negedge clk);
    #1 rst_n = 1; mode_en = 1;
    drive(0, 10);

    // R2 R3 R6: duty table over the frequency range
    for (int v = 0; v < NV; v++)
      for (int k = 0; k < VEC[v][2]; k++)
        period(VEC[v][0], VEC[v][1], "R2/R3/R6 table");

    hold_high(TO + 100);                      // R4

    period(250, 500, "R2");
    period(250, 500, "R2");
    period(100, 500, "R3");
    have_prev = 0;
    drive(0, TO + 100);                       // R5 stuck low
    #5;
    chk(ref_valid == 0, "R5 no result", ref_valid, 0);
    chk(ref_data == mstate, "R5 held", ref_data, mstate);

    period(100, 1000, "R7");
    period(100, 1000, "R7");
    have_prev = 0;
    #1 mode_en = 0;
    drive(1, 200); drive(0, 800);
    drive(1, 300); drive(0, 700);
    #5;
    chk(ref_valid == 0, "R7 idle", ref_valid, 0);
    chk(ref_data == mstate, "R7 state kept", ref_data, mstate);
    @(negedge clk);
    #1 mode_en = 1;
    drive(0, 10);
    period(300, 1000, "R7 rearm");
    period(300, 1000, "R7 rearm");
    period(300, 1000, "R7 rearm");

    @(negedge clk);
    #1 ref_ready = 0;                         // R8 stall
    period(400, 1000, "R8");
    period(700, 1000, "R8");
    period(900, 1000, "R8");
    @(negedge clk);
    #1 ref_ready = 1; port_busy = 0;
    period(200, 1000, "R8 after stall");
    period(600, 1000, "R8 after stall");
    drive(0, 100);
    chk(rd == wr, "R2 all results delivered", rd, wr);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule